// File: doc/BRIEF.md
# Finite-Difference Polynomial Tabulator

This block produces the successive entries of a polynomial table at integer arguments using nothing but additions. It holds a chain made of one value register and `ORDER` difference registers. A loader (software or a sequencer) computes f(0) and the forward differences of f at zero, writes them into the chain in a single cycle, and then issues step requests. Each accepted step emits the current table entry and advances every register of the chain by one argument on the same clock edge.

The step input is a valid/ready handshake. `step_ready` is low only while `load_en` is high, so a step offered during a load is refused and has no effect. The output side has no back-pressure: `out_valid` pulses for one cycle per accepted step, and the consumer must take `out_data` in that cycle. Between pulses `out_data` keeps its last value. A sticky flag records any carry out of the register width in the chain's adders. All arithmetic wraps modulo 2^WIDTH.

Top module: `fdt_tabulator`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is 0, `out_data` is 0, `overflow` is 0 and `step_ready` is 1.
- R2: A step is accepted on a rising edge where `step_valid` and `step_ready` are both 1. `out_valid` is 1 during the cycle after that edge and 0 after any edge with no accepted step.
- R3: An accepted step presents the table value held before the edge on `out_data`. The value register then becomes its old value plus the old first difference.
- R4: For each k from 1 to ORDER-1, difference k becomes its old value plus the old difference k+1 on an accepted step. Difference ORDER never changes except on load.
- R5: Loading f(0)=41 with first and second differences 2 and all higher ones 0, five steps give 41, 43, 47, 53, 61 in that order.
- R6: With the default ORDER of 6, any polynomial up to degree 6 is tabulated exactly. The bench checks f(n)=n^6+3n^2+7 for n=0..19.
- R7: When `load_en` is 1, one edge writes `load_value` into the value register and `load_diffs[(k-1)*WIDTH +: WIDTH]` into difference k. `step_ready` is 0 in that cycle, and a concurrent `step_valid` produces no output and does not advance the table.
- R8: `overflow` becomes 1 after an accepted step in which any chain addition carries out of WIDTH bits. It then stays 1 until a load, and the load clears it to 0.
- R9: Sums wrap modulo 2^WIDTH. A value of 0xFFFFFFF0 with first difference 0x20 yields 0x00000010 as the next entry.
- R10: `out_data` is unchanged in every cycle where `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Write the whole chain this cycle |
| load_value | input | WIDTH | Initial table value f(0) |
| load_diffs | input | ORDER*WIDTH | Initial differences; difference k at bits (k-1)*WIDTH upward |
| step_valid | input | 1 | Step request |
| step_ready | output | 1 | Step may be accepted (low during load) |
| out_valid | output | 1 | One-cycle pulse per accepted step |
| out_data | output | WIDTH | Emitted table entry |
| overflow | output | 1 | Sticky carry-out flag, cleared by load |

## Verification
An accepted step or a load takes effect on one edge, so `out_valid`, `out_data` and `overflow` are due in the cycle right after that edge. `step_ready` follows `load_en` within the same cycle. The bench drives inputs a little after the falling edge and compares every output against a behavioural model at each falling edge, which is mid-cycle between the edge that updates the design and the next one. Table sequences are also collected from the `out_valid` pulses and compared with values computed directly from the polynomial.

// File: rtl/fdt_pkg.sv
package fdt_pkg;
  localparam int unsigned FDT_WIDTH = 32;
  localparam int unsigned FDT_ORDER = 6;
endpackage

// File: rtl/fdt_stage.sv
module fdt_stage #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_val,
  input  logic             adv,
  input  logic [WIDTH-1:0] addend,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);
  logic [WIDTH:0] sum_w;

  assign sum_w     = {1'b0, q} + {1'b0, addend};
  assign carry_out = sum_w[WIDTH];

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (load_en) q <= load_val;
    else if (adv)     q <= sum_w[WIDTH-1:0];
  end
endmodule

// File: rtl/fdt_outreg.sv
module fdt_outreg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [WIDTH-1:0] din,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fire;
      if (fire) out_data <= din;
    end
  end
endmodule

// File: rtl/fdt_tabulator.sv
module fdt_tabulator
  import fdt_pkg::*;
#(
  parameter int unsigned WIDTH = FDT_WIDTH,
  parameter int unsigned ORDER = FDT_ORDER
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load_en,
  input  logic [WIDTH-1:0]       load_value,
  input  logic [ORDER*WIDTH-1:0] load_diffs,
  input  logic                   step_valid,
  output logic                   step_ready,
  output logic                   out_valid,
  output logic [WIDTH-1:0]       out_data,
  output logic                   overflow
);
  localparam int unsigned NREG = ORDER + 1;

  logic [WIDTH-1:0] chain_q [NREG];
  logic [NREG-1:0]  carry_v;
  logic             adv;
  logic             ovf_q;

  assign step_ready = ~load_en;
  assign adv        = step_valid & step_ready;

  for (genvar i = 0; i < NREG; i++) begin : g_chain
    logic [WIDTH-1:0] ld_w;
    logic [WIDTH-1:0] add_w;
    if (i == 0) begin : g_val
      assign ld_w = load_value;
    end else begin : g_diff
      assign ld_w = load_diffs[(i-1)*WIDTH +: WIDTH];
    end
    if (i < ORDER) begin : g_mid
      assign add_w = chain_q[i+1];
    end else begin : g_top
      assign add_w = '0;
    end
    fdt_stage #(.WIDTH(WIDTH)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .load_en  (load_en),
      .load_val (ld_w),
      .adv      (adv),
      .addend   (add_w),
      .q        (chain_q[i]),
      .carry_out(carry_v[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                  ovf_q <= 1'b0;
    else if (load_en)         ovf_q <= 1'b0;
    else if (adv && |carry_v) ovf_q <= 1'b1;
  end
  assign overflow = ovf_q;

  fdt_outreg #(.WIDTH(WIDTH)) u_out (
    .clk      (clk),
    .rst      (rst),
    .fire     (adv),
    .din      (chain_q[0]),
    .out_valid(out_valid),
    .out_data (out_data)
  );
endmodule

// File: rtl/fdt_checker.sv
module fdt_checker #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             load_en,
  input logic             step_valid,
  input logic             step_ready,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_data,
  input logic             overflow
);
  // R2
  step_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (step_valid && step_ready) |=> out_valid);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(step_valid && step_ready) |=> !out_valid);
  // R7
  load_block_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |-> !step_ready);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overflow && !load_en) |=> overflow);
  // R8
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> !overflow);
  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));
endmodule

bind fdt_tabulator fdt_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .load_en   (load_en),
  .step_valid(step_valid),
  .step_ready(step_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .overflow  (overflow)
);

// File: tb/fdt_tabulator_tb.sv
module fdt_tabulator_tb;
  localparam int W = 32;
  localparam int K = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_en = 1'b0;
  logic [W-1:0] load_value = '0;
  logic [K*W-1:0] load_diffs = '0;
  logic step_valid = 1'b0;
  logic step_ready, out_valid, overflow;
  logic [W-1:0] out_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  logic [W-1:0] m_f, m_out;
  logic [W-1:0] m_d [1:K];
  logic m_valid, m_ovf;
  logic [W-1:0] got [$];

  always #5 clk = ~clk;

  fdt_tabulator #(.WIDTH(W), .ORDER(K)) u_dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_value(load_value),
    .load_diffs(load_diffs), .step_valid(step_valid), .step_ready(step_ready),
    .out_valid(out_valid), .out_data(out_data), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    logic [W:0] s;
    cyc++;
    if (rst) begin
      m_f = '0; m_out = '0; m_valid = 0; m_ovf = 0;
      for (int k = 1; k <= K; k++) m_d[k] = '0;
    end else if (load_en) begin
      m_f = load_value; m_ovf = 0; m_valid = 0;
      for (int k = 1; k <= K; k++) m_d[k] = load_diffs[(k-1)*W +: W];
    end else if (step_valid) begin
      m_valid = 1; m_out = m_f;
      s = {1'b0, m_f} + {1'b0, m_d[1]};
      m_f = s[W-1:0];
      if (s[W]) m_ovf = 1;
      for (int k = 1; k < K; k++) begin
        s = {1'b0, m_d[k]} + {1'b0, m_d[k+1]};
        m_d[k] = s[W-1:0];
        if (s[W]) m_ovf = 1;
      end
    end else begin
      m_valid = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst && cyc > 0) begin
      chk(out_valid === m_valid, "R2 valid", W'(out_valid), W'(m_valid));
      chk(out_data === m_out, "R3 data", out_data, m_out);
      chk(overflow === m_ovf, "R8 overflow", W'(overflow), W'(m_ovf));
      chk(step_ready === !load_en, "R7 ready", W'(step_ready), W'(!load_en));
    end
    if (out_valid) got.push_back(out_data);
  end

  task automatic do_load(input logic [W-1:0] v, input logic [W-1:0] d [1:K], input bit with_step);
    @(negedge clk); #1;
    load_en = 1; load_value = v; step_valid = with_step;
    for (int k = 1; k <= K; k++) load_diffs[(k-1)*W +: W] = d[k];
    @(negedge clk); #1;
    load_en = 0; step_valid = 0;
  endtask

  task automatic do_steps(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1; step_valid = 1;
      if (gaps) begin @(negedge clk); #1; step_valid = 0; end
    end
    @(negedge clk); #1; step_valid = 0;
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] poly6(input int n);
    longint x = n;
    return W'(x*x*x*x*x*x + 3*x*x + 7);
  endfunction

  initial begin
    logic [W-1:0] d [1:K];
    logic [W-1:0] v [0:K];
    logic [W-1:0] exp5 [5] = '{41, 43, 47, 53, 61};
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(out_valid === 0 && overflow === 0 && out_data === 0 && step_ready === 1,
        "R1 reset", out_data, '0);
    #1 rst = 0;
    @(negedge clk);
    chk(out_valid === 0 && overflow === 0 && out_data === 0, "R1 after reset", out_data, '0);

    // R5 classic table
    for (int k = 1; k <= K; k++) d[k] = '0;
    d[1] = 2; d[2] = 2;
    do_load(41, d, 0);
    got.delete();
    do_steps(5, 0);
    chk(got.size() == 5, "R5 count", W'(got.size()), 5);
    for (int i = 0; i < 5 && i < got.size(); i++) chk(got[i] == exp5[i], "R5 entry", got[i], exp5[i]);

    // R7 step offered during load is ignored
    d[1] = 5; d[2] = 0;
    do_load(100, d, 1);
    chk(out_valid === 0, "R7 no output on load", W'(out_valid), 0);
    got.delete();
    do_steps(2, 0);
    chk(got.size() == 2 && got[0] == 100 && got[1] == 105, "R7 not advanced", got.size() > 0 ? got[0] : '1, 100);

    // R6 R3 R4 degree-6 polynomial with gaps between steps (R10 hold)
    for (int i = 0; i <= K; i++) v[i] = poly6(i);
    for (int k = 1; k <= K; k++)
      for (int i = K; i >= k; i--) v[i] = v[i] - v[i-1];
    for (int k = 1; k <= K; k++) d[k] = v[k];
    do_load(v[0], d, 0);
    got.delete();
    do_steps(20, 1);
    chk(got.size() == 20, "R6 count", W'(got.size()), 20);
    for (int i = 0; i < 20 && i < got.size(); i++) chk(got[i] == poly6(i), "R6 entry", got[i], poly6(i));

    // R9 R8 wrap and sticky overflow from value adder
    for (int k = 1; k <= K; k++) d[k] = '0;
    d[1] = 32'h20;
    do_load(32'hFFFF_FFF0, d, 0);
    got.delete();
    do_steps(2, 0);
    chk(got.size() == 2 && got[1] == 32'h10, "R9 wrap", got.size() > 1 ? got[1] : '1, 32'h10);
    chk(overflow === 1, "R8 set", W'(overflow), 1);
    repeat (3) @(negedge clk);
    chk(overflow === 1, "R8 sticky", W'(overflow), 1);
    do_load(0, d, 0);
    chk(overflow === 0, "R8 clear on load", W'(overflow), 0);

    // R8 carry inside the difference chain only
    for (int k = 1; k <= K; k++) d[k] = '0;
    d[5] = 32'h8000_0000; d[6] = 32'h8000_0000;
    do_load(0, d, 0);
    do_steps(1, 0);
    chk(overflow === 1, "R8 high-order carry", W'(overflow), 1);
    chk(got.size() > 0 && got[got.size()-1] == 0, "R4 value unchanged", out_data, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule